// File: doc/BRIEF.md
# Programmable down-counting frequency divider

This block divides its clock by a programmable ratio. A binary down-counter steps down by one on every rising clock edge. When it wraps it reloads the ratio and raises a pulse for exactly one clock. That pulse is the divided signal that feeds a phase comparator. A second, gated copy of the pulse serves as an observation output and stays low until software enables it.

A single parameter selects one of two builds:

- **Reference path:** 15-bit ratio, legal range 5 to 32,767. A ratio of 1 bypasses the counter, so every input clock produces a pulse.
- **Oscillator-feedback path:** 16-bit ratio, legal range 40 to 65,535.

Ratios below the minimum are raised to it. The bypass value counts as legal only on the reference path.

The control is a two-state machine:

- **`ST_RUN`** counts down. Its *count-down* transition decrements the count. Its *reload-to-run* or *reload-to-bypass* transition fires when the count is 1.
- **`ST_BYPASS`** reloads on every cycle. Its *bypass-hold* transition keeps the ratio 1, and its *reload-to-run* transition leaves bypass as soon as a normal ratio is pending.

A ratio is written with a load strobe and held as the pending ratio. It becomes active only when the counter wraps, so a running period is never cut short.

Top module: `prog_divider`

## Requirements
- R1: During synchronous reset and immediately after it, both outputs are low. The pending ratio is the path minimum, and the first pulse appears on the MIN-th rising edge after reset is released.
- R2: In `ST_RUN` the count falls by one per clock. The divided pulse is high for exactly one clock per period, and the period equals the active ratio in clocks.
- R3: The reference build (`PATH_REF`, 15-bit `ratio_i`) accepts every ratio from 5 to 32,767 unchanged.
- R4: The feedback build (`PATH_VCO`, 16-bit `ratio_i`) accepts every ratio from 40 to 65,535 unchanged.
- R5: A written ratio below the path minimum is replaced by the minimum. This covers 0, 2 to 4 on the reference path, and 0 to 39 on the feedback path, including 1.
- R6: On the reference path, a ratio of 1 enters `ST_BYPASS`, and there `div_pulse_o` is high on every clock.
- R7: A ratio written with `ratio_load_i` is applied at the next wrap. A write on the same edge as a wrap takes effect at that wrap.
- R8: `div_ext_o` equals `div_pulse_o` when `out_en_i` was 1 at the wrap edge, and is low otherwise.
- R9: Writing a legal ratio while in `ST_BYPASS` returns to `ST_RUN`, and the next pulse follows after that many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 15 (ref) / 16 (VCO) | Ratio to write |
| ratio_load_i | input | 1 | Write strobe for `ratio_i` |
| out_en_i | input | 1 | Enable for the gated copy |
| div_pulse_o | output | 1 | Divided pulse to the phase comparator |
| div_ext_o | output | 1 | Gated copy of the divided pulse |

## Verification
The bench builds two instances side by side from one stimulus stream: one with `PATH=PATH_REF` and one with `PATH=PATH_VCO`. Because of this, a single write reaches both path minimums at once. For example, a write of 1 means bypass on the reference instance and clamping to 40 on the feedback instance. A write of all ones gives the largest ratio of each width, so both full-length periods (32,767 and 65,535 clocks) are covered.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic { PATH_REF, PATH_VCO } div_path_e;

    typedef enum logic { ST_RUN, ST_BYPASS } div_state_e;

    function automatic int path_width(div_path_e p);
        return (p == PATH_REF) ? 15 : 16;
    endfunction

    function automatic int path_min(div_path_e p);
        return (p == PATH_REF) ? 5 : 40;
    endfunction

    function automatic bit path_bypass(div_path_e p);
        return (p == PATH_REF);
    endfunction

endpackage

// File: rtl/div_ratio_hold.sv
module div_ratio_hold #(
    parameter int W   = 16,
    parameter int MIN = 40,
    parameter bit BYP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] ratio_i,
    output logic [W-1:0] ratio_next_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN);
    localparam logic [W-1:0] ONE   = W'(1);

    logic [W-1:0] pend_q;
    logic [W-1:0] legal;

    // range handling: bypass value passes on the reference path, the rest clamp up
    always_comb begin
        if (BYP && ratio_i == ONE) begin
            legal = ONE;
        end else if (ratio_i < MIN_V) begin
            legal = MIN_V;
        end else begin
            legal = ratio_i;
        end
    end

    assign ratio_next_o = load_i ? legal : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= MIN_V;
        end else begin
            pend_q <= ratio_next_o;
        end
    end

    assert_pend_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_q >= MIN_V) || (BYP && pend_q == ONE));

endmodule

// File: rtl/div_count_fsm.sv
module div_count_fsm import div_pkg::*; #(
    parameter int W   = 16,
    parameter int MIN = 40,
    parameter bit BYP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_next_i,
    output logic         wrap_o,
    output logic         pulse_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN);
    localparam logic [W-1:0] ONE   = W'(1);

    div_state_e   state_q, state_d;
    logic [W-1:0] count_q, count_d;
    logic         pulse_q;
    logic         to_bypass;

    assign to_bypass = BYP && (ratio_next_i == ONE);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        wrap_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (count_q == ONE) begin
                    wrap_o  = 1'b1;
                    count_d = ratio_next_i;
                    state_d = to_bypass ? ST_BYPASS : ST_RUN;
                end else begin
                    count_d = count_q - ONE;
                end
            end
            ST_BYPASS: begin
                wrap_o  = 1'b1;
                count_d = ratio_next_i;
                state_d = to_bypass ? ST_BYPASS : ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            count_q <= MIN_V;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap_o;
        end
    end

    assign pulse_o = pulse_q;

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && count_q != ONE) |=> (count_q == $past(count_q) - ONE));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && state_q == ST_RUN) |=> !pulse_q);

    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        count_q != '0);

    assert_bypass_ref_only_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BYPASS) |-> (BYP && count_q == ONE && pulse_q));

endmodule

// File: rtl/div_out_gate.sv
module div_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic en_i,
    output logic ext_o
);
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= wrap_i & en_i;
        end
    end

    assign ext_o = ext_q;

endmodule

// File: rtl/prog_divider.sv
module prog_divider import div_pkg::*; #(
    parameter  div_path_e PATH = PATH_VCO,
    localparam int        W    = path_width(PATH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_i,
    input  logic         ratio_load_i,
    input  logic         out_en_i,
    output logic         div_pulse_o,
    output logic         div_ext_o
);
    localparam int MIN = path_min(PATH);
    localparam bit BYP = path_bypass(PATH);

    logic [W-1:0] ratio_next;
    logic         wrap;

    div_ratio_hold #(.W(W), .MIN(MIN), .BYP(BYP)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .load_i       (ratio_load_i),
        .ratio_i      (ratio_i),
        .ratio_next_o (ratio_next)
    );

    div_count_fsm #(.W(W), .MIN(MIN), .BYP(BYP)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ratio_next_i (ratio_next),
        .wrap_o       (wrap),
        .pulse_o      (div_pulse_o)
    );

    div_out_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .wrap_i (wrap),
        .en_i   (out_en_i),
        .ext_o  (div_ext_o)
    );

    assert_ext_within_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        div_ext_o |-> div_pulse_o);

endmodule

// File: tb/test_prog_divider.sv
module div_exp_model #(
    parameter int W   = 16,
    parameter int MIN = 40,
    parameter bit BYP = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ratio,
    input  logic        load,
    input  logic        en,
    output logic        pulse,
    output logic        ext
);
    int pend;
    int cnt;
    int np;

    function automatic int exp_ratio(int r);
        if (BYP && r == 1) return 1;
        if (r < MIN) return MIN;
        return r;
    endfunction

    always_comb np = load ? exp_ratio(int'(ratio) % (1 << W)) : pend;

    always @(posedge clk) begin
        if (rst) begin
            pend  <= MIN;
            cnt   <= MIN;
            pulse <= 1'b0;
            ext   <= 1'b0;
        end else begin
            pend <= np;
            if (cnt == 1) begin
                cnt   <= np;
                pulse <= 1'b1;
                ext   <= en;
            end else begin
                cnt   <= cnt - 1;
                pulse <= 1'b0;
                ext   <= 1'b0;
            end
        end
    end
endmodule

module test_prog_divider;
    import div_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ratio = '0;
    logic        load = 1'b0;
    logic        en = 1'b0;
    logic        r_pulse, r_ext, v_pulse, v_ext;
    logic        mr_pulse, mr_ext, mv_pulse, mv_ext;
    int          checks = 0;
    int          fails = 0;
    string       cur_req = "R1";

    always #10 clk = ~clk;

    prog_divider #(.PATH(PATH_REF)) i_prog_divider (
        .clk(clk), .rst(rst), .ratio_i(ratio[14:0]), .ratio_load_i(load),
        .out_en_i(en), .div_pulse_o(r_pulse), .div_ext_o(r_ext));

    prog_divider #(.PATH(PATH_VCO)) i_prog_divider_vco (
        .clk(clk), .rst(rst), .ratio_i(ratio), .ratio_load_i(load),
        .out_en_i(en), .div_pulse_o(v_pulse), .div_ext_o(v_ext));

    div_exp_model #(.W(15), .MIN(5), .BYP(1'b1)) m_ref (
        .clk(clk), .rst(rst), .ratio(ratio), .load(load), .en(en),
        .pulse(mr_pulse), .ext(mr_ext));

    div_exp_model #(.W(16), .MIN(40), .BYP(1'b0)) m_vco (
        .clk(clk), .rst(rst), .ratio(ratio), .load(load), .en(en),
        .pulse(mv_pulse), .ext(mv_ext));

    task automatic cmp(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, what, $time, act, exp);
        end
    endtask

    task automatic cmp_all();
        cmp("ref pulse", r_pulse, mr_pulse);
        cmp("ref ext",   r_ext,   mr_ext);
        cmp("vco pulse", v_pulse, mv_pulse);
        cmp("vco ext",   v_ext,   mv_ext);
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            cmp_all();
        end
    endtask

    task automatic write(logic [15:0] r);
        ratio = r;
        load  = 1'b1;
        run(1);
        load  = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        run(3);
        cur_req = "R1";
        cmp("ref pulse in reset", r_pulse, 1'b0);
        cmp("vco ext in reset", v_ext, 1'b0);
        rst = 1'b0;
        cur_req = "R1 R2";
        run(90);
        en = 1'b1;
        cur_req = "R8";
        run(100);
        cur_req = "R5 R7";
        write(16'd7);
        run(120);
        cur_req = "R6";
        write(16'd1);
        run(50);
        cur_req = "R9";
        write(16'd45);
        run(100);
        cur_req = "R5";
        write(16'd0);
        run(100);
        write(16'd3);
        run(100);
        cur_req = "R8";
        en = 1'b0;
        write(16'd12);
        run(100);
        en = 1'b1;
        cur_req = "R3 R4";
        write(16'hFFFF);
        run(66000);
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cmp_all();
            load  = ($urandom % 20) == 0;
            ratio = (($urandom % 8) == 0) ? 16'($urandom % 400) : 16'($urandom % 50);
            if (($urandom % 40) == 0) en = ~en;
        end
        load = 1'b0;
        cur_req = "R1";
        rst = 1'b1;
        run(2);
        cmp("ref ext after reset", r_ext, 1'b0);
        cmp("vco pulse after reset", v_pulse, 1'b0);
        rst = 1'b0;
        run(90);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule